// File: doc/BRIEF.md
# Two-Group Parallel Digital I/O Register File

A byte-wide, bus-addressed peripheral that drives and senses 48 digital lines. The lines form two identical groups, and each group has three 8-bit ports (A, B and C) and one control byte. The control byte sets the direction of port A and port B as whole ports. It sets the direction of port C one nibble at a time. The same control byte also accepts a single-bit set/clear command for port C. Writes to a port load its output latch. A read returns the latch for bits configured as outputs and the synchronised pin level for bits configured as inputs.

The block also contains one card-level interrupt request. Its only sources are bit 3 of port C in each group. These are flat lines 19 and 43, where the flat line number is group*24 + port*8 + bit, and ports A, B and C count as 0, 1 and 2. Each source is synchronised, and the block raises the request on a rising edge. Enabling, disabling and clearing the interrupt are side effects of accesses to fixed offsets. There is no mask register. A host drives one synchronous read or write strobe per cycle, and read data is combinational from the address.

Top module: `pio48_regfile`

## Requirements
- R1: While reset is asserted and after it is released, every line is an output (`pin_oe` all ones), every output latch is 0, and `irq_req` is 0.
- R2: A write to a port offset (group g at offsets 4g+0, 4g+1 and 4g+2 for ports A, B and C) loads that port's 8-bit latch, and the latch appears on `pin_out` at flat bits g*24+port*8 in the next cycle.
- R3: A write to a control offset (3 or 7) with bit 7 = 1 sets the direction. Bit 4 = 1 makes port A an input, bit 1 = 1 makes port B an input, bit 0 = 1 makes port C bits 3:0 an input, and bit 3 = 1 makes port C bits 7:4 an input. A 0 in any of these bits means output, and `pin_oe` is 1 for output bits.
- R4: A direction write also clears all three output latches of that group to 0. The other group is left unchanged.
- R5: Reading a port returns the latch bit for output bits. For input bits it returns `pin_in` after a two-flip-flop synchroniser, so a pin change is seen two clocks later.
- R6: A control write with bit 7 = 0 is a port C bit command. Bits 3:1 choose the bit and bit 0 is its new value. The command has no effect when the chosen bit is configured as an input.
- R7: With the interrupt enabled, a rising edge on synchronised line 19 or 43 sets `irq_req`. The request appears three clocks after the pin rises and stays asserted until it is cleared.
- R8: A read of offset 0xB disables the interrupt and a write of any value to 0xB enables it. Edges that arrive while the interrupt is disabled are lost and do not assert `irq_req` later.
- R9: A write of any value to offset 0xF clears `irq_req`. A clear wins over an edge that qualifies in the same cycle.
- R10: A read of any offset from 8 to 15 (including 0xB) returns 0xFF. A read of a control offset returns {1, 0, 0, A-in, Chi-in, 0, B-in, Clo-in}. Reads at these offsets, other than 0xB, have no side effect.
- R11: Falling edges on lines 19 and 43, and edges on any other line, never assert `irq_req`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Byte offset within the 16-byte window |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, used for read side effects |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| pin_in | input | 48 | Pin levels sensed from the lines |
| pin_out | output | 48 | Output latch values |
| pin_oe | output | 48 | Per-line output enable (1 = drive) |
| irq_req | output | 1 | Level interrupt request |

## Verification
The case that is hardest to reach from the ports is an interrupt clear that lands in exactly the cycle in which a synchronised edge qualifies. The stimulus raises line 19 just after a falling clock edge. It then waits two rising edges and issues the 0xF write so that the strobe covers the third rising edge. Two further situations are built on purpose. One is an edge that arrives while the interrupt is disabled and must stay lost after re-enabling. The other is a bit command aimed at an input-configured port C bit, whose untouched latch is observed on `pin_out`.

// File: rtl/pio48_pkg.sv
package pio48_pkg;

   typedef struct packed {
      logic a_in;
      logic b_in;
      logic clo_in;
      logic chi_in;
   } dir_t;

   localparam int MODE_BIT    = 7;
   localparam int A_DIR_BIT   = 4;
   localparam int CHI_DIR_BIT = 3;
   localparam int B_DIR_BIT   = 1;
   localparam int CLO_DIR_BIT = 0;

   localparam logic [1:0] SEL_A    = 2'd0;
   localparam logic [1:0] SEL_B    = 2'd1;
   localparam logic [1:0] SEL_C    = 2'd2;
   localparam logic [1:0] SEL_CTRL = 2'd3;

   localparam logic [3:0] OFS_IRQ_GATE  = 4'hB;
   localparam logic [3:0] OFS_IRQ_CLEAR = 4'hF;

   function automatic logic [7:0] ctrl_image(input dir_t d);
      logic [7:0] v;
      v = 8'h80;
      v[A_DIR_BIT]   = d.a_in;
      v[CHI_DIR_BIT] = d.chi_in;
      v[B_DIR_BIT]   = d.b_in;
      v[CLO_DIR_BIT] = d.clo_in;
      return v;
   endfunction

endpackage

// File: rtl/pio48_group.sv
module pio48_group
   import pio48_pkg::*;
#(
   parameter int PORT_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int IRQ_BIT     = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [1:0]            wr_sel,
   input  logic [PORT_W-1:0]     wdata,
   input  logic [1:0]            rd_sel,
   output logic [PORT_W-1:0]     rdata,
   input  logic [3*PORT_W-1:0]   pins_in,
   output logic [3*PORT_W-1:0]   pins_out,
   output logic [3*PORT_W-1:0]   pins_oe,
   output logic                  irq_src
);
   localparam int LANES = 3 * PORT_W;
   localparam int HALF  = PORT_W / 2;
   localparam int IDX_W = $clog2(PORT_W);

   if (PORT_W != 8) begin : g_bad_width
      $error("pio48_group: control encoding requires PORT_W == 8");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("pio48_group: SYNC_STAGES must be at least 2");
   end
   if (IRQ_BIT >= PORT_W) begin : g_bad_irq
      $error("pio48_group: IRQ_BIT outside port C");
   end

   logic [PORT_W-1:0] lat_a, lat_b, lat_c;
   logic [PORT_W-1:0] oe_a, oe_b, oe_c;
   dir_t              dir_q;
   logic [IDX_W-1:0]  bit_idx;

   assign bit_idx = wdata[IDX_W:1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_a <= '0;
         lat_b <= '0;
         lat_c <= '0;
         dir_q <= '0;
      end else if (wr_en) begin
         case (wr_sel)
            SEL_A: lat_a <= wdata;
            SEL_B: lat_b <= wdata;
            SEL_C: lat_c <= wdata;
            default: begin
               if (wdata[MODE_BIT]) begin
                  dir_q.a_in   <= wdata[A_DIR_BIT];
                  dir_q.b_in   <= wdata[B_DIR_BIT];
                  dir_q.clo_in <= wdata[CLO_DIR_BIT];
                  dir_q.chi_in <= wdata[CHI_DIR_BIT];
                  lat_a <= '0;
                  lat_b <= '0;
                  lat_c <= '0;
               end else if (oe_c[bit_idx]) begin
                  lat_c[bit_idx] <= wdata[0];
               end
            end
         endcase
      end
   end

   assign oe_a = {PORT_W{~dir_q.a_in}};
   assign oe_b = {PORT_W{~dir_q.b_in}};
   assign oe_c = {{HALF{~dir_q.chi_in}}, {HALF{~dir_q.clo_in}}};

   assign pins_out = {lat_c, lat_b, lat_a};
   assign pins_oe  = {oe_c, oe_b, oe_a};

   logic [LANES-1:0] sync_q [SYNC_STAGES];

   for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sync_q[s] <= '0;
         end else begin
            if (s == 0) begin
               sync_q[s] <= pins_in;
            end else begin
               sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
            end
         end
      end
   end

   logic [LANES-1:0] synced;
   logic [LANES-1:0] view;

   assign synced  = sync_q[SYNC_STAGES-1];
   assign view    = (pins_out & pins_oe) | (synced & ~pins_oe);
   assign irq_src = synced[2*PORT_W + IRQ_BIT];

   always_comb begin
      case (rd_sel)
         SEL_A:   rdata = view[PORT_W-1:0];
         SEL_B:   rdata = view[2*PORT_W-1:PORT_W];
         SEL_C:   rdata = view[3*PORT_W-1:2*PORT_W];
         default: rdata = ctrl_image(dir_q);
      endcase
   end

endmodule

// File: rtl/pio48_irq.sv
module pio48_irq #(
   parameter int NUM_SRC = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src,
   input  logic               arm,
   input  logic               disarm,
   input  logic               clear,
   output logic               irq
);
   if (NUM_SRC < 1) begin : g_bad_src
      $error("pio48_irq: NUM_SRC must be positive");
   end

   logic [NUM_SRC-1:0] prev_q;
   logic [NUM_SRC-1:0] rise;
   logic               armed_q;
   logic               pend_q;

   assign rise = src & ~prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= '0;
         armed_q <= 1'b0;
         pend_q  <= 1'b0;
      end else begin
         prev_q <= src;
         if (arm) begin
            armed_q <= 1'b1;
         end else if (disarm) begin
            armed_q <= 1'b0;
         end
         if (clear) begin
            pend_q <= 1'b0;
         end else if (armed_q && (|rise)) begin
            pend_q <= 1'b1;
         end
      end
   end

   assign irq = pend_q;

endmodule

// File: rtl/pio48_regfile.sv
module pio48_regfile
   import pio48_pkg::*;
#(
   parameter int NUM_GROUPS  = 2,
   parameter int PORT_W      = 8,
   parameter int ADDR_W      = 4,
   parameter int SYNC_STAGES = 2,
   parameter int IRQ_BIT     = 3
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [ADDR_W-1:0]              bus_addr,
   input  logic                           bus_wr,
   input  logic                           bus_rd,
   input  logic [PORT_W-1:0]              bus_wdata,
   output logic [PORT_W-1:0]              bus_rdata,
   input  logic [NUM_GROUPS*3*PORT_W-1:0] pin_in,
   output logic [NUM_GROUPS*3*PORT_W-1:0] pin_out,
   output logic [NUM_GROUPS*3*PORT_W-1:0] pin_oe,
   output logic                           irq_req
);
   localparam int GROUP_LINES = 3 * PORT_W;
   localparam int GIDX_W      = ADDR_W - 2;

   if (ADDR_W != 4) begin : g_bad_addr
      $error("pio48_regfile: window is fixed at 16 bytes");
   end
   if (NUM_GROUPS < 1 || NUM_GROUPS * 4 > 8) begin : g_bad_groups
      $error("pio48_regfile: groups must fit below offset 8");
   end

   logic [GIDX_W-1:0] grp_idx;
   logic [1:0]        reg_sel;
   logic              grp_hit;
   logic              gate_hit;
   logic              clear_hit;

   assign grp_idx   = bus_addr[ADDR_W-1:2];
   assign reg_sel   = bus_addr[1:0];
   assign grp_hit   = (int'(grp_idx) < NUM_GROUPS);
   assign gate_hit  = (bus_addr == OFS_IRQ_GATE);
   assign clear_hit = (bus_addr == OFS_IRQ_CLEAR);

   logic [PORT_W-1:0]     grp_rdata [NUM_GROUPS];
   logic [NUM_GROUPS-1:0] irq_src;

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      logic wr_en_g;
      assign wr_en_g = bus_wr && grp_hit && (int'(grp_idx) == g);

      pio48_group #(
         .PORT_W      (PORT_W),
         .SYNC_STAGES (SYNC_STAGES),
         .IRQ_BIT     (IRQ_BIT)
      ) u_group (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (wr_en_g),
         .wr_sel   (reg_sel),
         .wdata    (bus_wdata),
         .rd_sel   (reg_sel),
         .rdata    (grp_rdata[g]),
         .pins_in  (pin_in [g*GROUP_LINES +: GROUP_LINES]),
         .pins_out (pin_out[g*GROUP_LINES +: GROUP_LINES]),
         .pins_oe  (pin_oe [g*GROUP_LINES +: GROUP_LINES]),
         .irq_src  (irq_src[g])
      );
   end

   always_comb begin
      bus_rdata = '1;
      for (int g = 0; g < NUM_GROUPS; g++) begin
         if (grp_hit && (int'(grp_idx) == g)) begin
            bus_rdata = grp_rdata[g];
         end
      end
   end

   pio48_irq #(
      .NUM_SRC (NUM_GROUPS)
   ) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .src    (irq_src),
      .arm    (bus_wr && gate_hit),
      .disarm (bus_rd && gate_hit),
      .clear  (bus_wr && clear_hit),
      .irq    (irq_req)
   );

endmodule

// File: rtl/pio48_chk.sv
module pio48_chk #(
   parameter int NUM_GROUPS = 2,
   parameter int PORT_W     = 8,
   parameter int ADDR_W     = 4
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic [ADDR_W-1:0]              bus_addr,
   input logic                           bus_wr,
   input logic                           bus_rd,
   input logic [PORT_W-1:0]              bus_wdata,
   input logic [PORT_W-1:0]              bus_rdata,
   input logic [NUM_GROUPS*3*PORT_W-1:0] pin_out,
   input logic [NUM_GROUPS*3*PORT_W-1:0] pin_oe,
   input logic                           irq_req
);
   localparam int GL = 3 * PORT_W;

   logic ctrl0_wr;
   assign ctrl0_wr = bus_wr && (bus_addr == 4'h3);

   // R9: a clear write always leaves the request low
   assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 4'hF) |=> !irq_req);

   // R7: the request holds until a clear write
   assert_irq_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && !(bus_wr && bus_addr == 4'hF)) |=> irq_req);

   // R10: upper half of the window reads all ones
   assert_upper_ff_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr[ADDR_W-1]) |-> (bus_rdata == '1));

   // R4: direction command zeroes group 0 latches
   assert_dir_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl0_wr && bus_wdata[7]) |=> (pin_out[GL-1:0] == '0));

   // R3: group 0 enables change only through its control byte
   assert_oe_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl0_wr |=> $stable(pin_oe[GL-1:0]));

endmodule

bind pio48_regfile pio48_chk #(
   .NUM_GROUPS (NUM_GROUPS),
   .PORT_W     (PORT_W),
   .ADDR_W     (ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .pin_out   (pin_out),
   .pin_oe    (pin_oe),
   .irq_req   (irq_req)
);

// File: tb/pio48_regfile_tb_top.sv
`timescale 1ns/1ps
module pio48_regfile_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic [47:0] pin_in = '0;
   logic [47:0] pin_out;
   logic [47:0] pin_oe;
   logic        irq_req;

   always #2 clk = ~clk;

   pio48_regfile dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_req(irq_req)
   );

   int tests = 0;
   int fails = 0;
   bit done  = 0;

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference model
   bit [7:0]  m_lat [2][3];
   bit        m_ain [2], m_bin [2], m_clo [2], m_chi [2];
   bit [47:0] m_s1, m_s2;
   bit        m_prev [2];
   bit        m_en, m_pend;

   function automatic bit [7:0] m_oe_byte(int g, int p);
      if (p == 0) return m_ain[g] ? 8'h00 : 8'hFF;
      if (p == 1) return m_bin[g] ? 8'h00 : 8'hFF;
      return {{4{~m_chi[g]}}, {4{~m_clo[g]}}};
   endfunction

   function automatic bit [47:0] m_oe_all();
      bit [47:0] v;
      for (int g = 0; g < 2; g++)
         for (int p = 0; p < 3; p++) v[g*24 + p*8 +: 8] = m_oe_byte(g, p);
      return v;
   endfunction

   function automatic bit [47:0] m_out_all();
      bit [47:0] v;
      for (int g = 0; g < 2; g++)
         for (int p = 0; p < 3; p++) v[g*24 + p*8 +: 8] = m_lat[g][p];
      return v;
   endfunction

   function automatic bit [7:0] m_read(bit [3:0] a);
      int g, p;
      bit [7:0] oe;
      if (a[3]) return 8'hFF;
      g = a[2];
      p = a[1:0];
      if (p == 3) return {1'b1, 2'b00, m_ain[g], m_chi[g], 1'b0, m_bin[g], m_clo[g]};
      oe = m_oe_byte(g, p);
      return (m_lat[g][p] & oe) | (m_s2[g*24 + p*8 +: 8] & ~oe);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int g = 0; g < 2; g++) begin
            for (int p = 0; p < 3; p++) m_lat[g][p] = 8'h00;
            m_ain[g] = 0; m_bin[g] = 0; m_clo[g] = 0; m_chi[g] = 0;
            m_prev[g] = 0;
         end
         m_s1 = '0; m_s2 = '0; m_en = 0; m_pend = 0;
      end else begin
         bit edge_seen;
         edge_seen = (m_s2[19] && !m_prev[0]) || (m_s2[43] && !m_prev[1]);
         if (bus_wr && bus_addr == 4'hF) m_pend = 0;
         else if (m_en && edge_seen) m_pend = 1;
         m_prev[0] = m_s2[19];
         m_prev[1] = m_s2[43];
         m_s2 = m_s1;
         m_s1 = pin_in;
         if (bus_wr && bus_addr == 4'hB) m_en = 1;
         else if (bus_rd && bus_addr == 4'hB) m_en = 0;
         if (bus_wr && !bus_addr[3]) begin
            int g, p;
            g = bus_addr[2];
            p = bus_addr[1:0];
            if (p < 3) m_lat[g][p] = bus_wdata;
            else if (bus_wdata[7]) begin
               m_ain[g] = bus_wdata[4]; m_bin[g] = bus_wdata[1];
               m_clo[g] = bus_wdata[0]; m_chi[g] = bus_wdata[3];
               for (int q = 0; q < 3; q++) m_lat[g][q] = 8'h00;
            end else begin
               int b;
               b = bus_wdata[3:1];
               if (m_oe_byte(g, 2)[b]) m_lat[g][2][b] = bus_wdata[0];
            end
         end
      end
   end

   // per-cycle comparison with the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("R2 model pin_out", pin_out, m_out_all());
         check("R3 model pin_oe", pin_oe, m_oe_all());
         check("R7 model irq_req", irq_req, m_pend);
      end
   end

   task automatic wr(input bit [3:0] a, input bit [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1;
      @(posedge clk);
      #1 bus_wr = 0;
   endtask

   task automatic rd(input bit [3:0] a, input string tag, output bit [7:0] v);
      @(negedge clk);
      bus_addr = a; bus_rd = 1;
      #1;
      v = bus_rdata;
      check(tag, bus_rdata, m_read(a));
      @(posedge clk);
      #1 bus_rd = 0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         done = 1;
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      bit [7:0] v;
      #1;
      check("R1 reset oe", pin_oe, 48'hFFFF_FFFF_FFFF);
      check("R1 reset out", pin_out, 48'h0);
      check("R1 reset irq", irq_req, 1'b0);
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1;
      idle(2);
      check("R1 after release oe", pin_oe, 48'hFFFF_FFFF_FFFF);

      // R2 port writes
      wr(4'h0, 8'h5A); wr(4'h1, 8'hC3); wr(4'h2, 8'h0F);
      wr(4'h4, 8'h11); wr(4'h5, 8'h22); wr(4'h6, 8'h33);
      check("R2 latches", pin_out, 48'h33_22_11_0F_C3_5A);

      // R3/R4 direction command on group 0
      wr(4'h3, 8'h91);
      check("R3 oe after dir", pin_oe, 48'hFFFFFF_F0FF00);
      check("R4 group0 cleared", pin_out, 48'h332211_000000);
      rd(4'h3, "R10 ctrl image g0", v);
      check("R10 ctrl image value", v, 8'h91);

      // R5 mixed reads
      pin_in[7:0] = 8'hA5;
      pin_in[23:16] = 8'h6C;
      wr(4'h2, 8'hB0);
      idle(3);
      rd(4'h0, "R5 port A input", v);
      check("R5 port A value", v, 8'hA5);
      rd(4'h2, "R5 port C mixed", v);
      check("R5 port C value", v, 8'hBC);

      // R6 bit commands
      wr(4'h3, 8'h0D);
      check("R6 set output bit", pin_out[23:16], 8'hF0);
      wr(4'h3, 8'h05);
      check("R6 input bit ignored", pin_out[23:16], 8'hF0);

      // R7 interrupt
      pin_in = '0;
      idle(4);
      wr(4'hB, 8'h00);
      check("R7 idle irq", irq_req, 1'b0);
      @(negedge clk) pin_in[19] = 1;
      idle(4);
      check("R7 irq set", irq_req, 1'b1);
      idle(5);
      check("R7 irq held", irq_req, 1'b1);
      wr(4'hF, 8'h55);
      check("R9 irq cleared", irq_req, 1'b0);

      // R8 disabled edges lost
      rd(4'hB, "R10 gate read", v);
      check("R10 gate read value", v, 8'hFF);
      @(negedge clk) pin_in[43] = 1;
      idle(5);
      check("R8 disabled no irq", irq_req, 1'b0);
      wr(4'hB, 8'hA7);
      idle(3);
      check("R8 edge not latched", irq_req, 1'b0);
      @(negedge clk) pin_in[43] = 0;
      idle(4);
      @(negedge clk) pin_in[43] = 1;
      idle(4);
      check("R8 re-enabled irq", irq_req, 1'b1);
      wr(4'hF, 8'h00);

      // R11 falling edges and other bits
      @(negedge clk) pin_in[19] = 0;
      idle(5);
      check("R11 falling edge", irq_req, 1'b0);
      @(negedge clk) begin pin_in[18] = 1; pin_in[42] = 1; pin_in[0] = 1; end
      idle(5);
      check("R11 other bits", irq_req, 1'b0);

      // R9 clear in the same cycle as a qualifying edge
      @(negedge clk) pin_in[19] = 1;
      @(posedge clk);
      @(posedge clk);
      wr(4'hF, 8'h01);
      check("R9 clear wins", irq_req, 1'b0);
      idle(3);
      check("R9 edge consumed", irq_req, 1'b0);

      // R10 unmapped reads
      rd(4'h9, "R10 unmapped", v);
      check("R10 unmapped value", v, 8'hFF);
      rd(4'hF, "R10 clear offset read", v);
      check("R10 clear read value", v, 8'hFF);
      rd(4'h7, "R10 ctrl image g1", v);
      check("R10 ctrl g1 value", v, 8'h80);
      idle(2);
      check("R10 no side effect", pin_out, 48'h332211_F00000);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule